// File: doc/BRIEF.md
# Privileged Control Register Bank with Interrupt Side Effects

This block holds a small set of 64-bit privileged control registers. They are reached through a register-select address with a write strobe and a read strobe. The central register is a soft-interrupt pending word, which has three write ports. A direct port replaces the whole word. A set port ORs bits into it, and a clear port removes bits from it, so software can change single bits without a read-modify-write sequence.

The bank also holds:
- an interrupt priority level,
- a processor-state word that carries an interrupt-enable bit,
- a trap base address,
- a hypervisor state word,
- a read-only version word,
- eight interrupt-queue head/tail pointers.

Some writes can change which interrupt should be taken. Those writes raise a one-cycle re-evaluate pulse for the interrupt logic outside the block. The block itself does no prioritizing and delivers no traps. It only exposes the register values and the pulse.

Address map:

| Select | Register | Access |
|--------|----------|--------|
| 0 | direct pending word | read/write |
| 1 | set alias | read/write |
| 2 | clear alias | read/write |
| 3 | priority level | read/write |
| 4 | processor state | read/write |
| 5 | trap base | read/write |
| 6 | version | read-only |
| 7 | hypervisor state | read/write |
| 8 to 15 | queue pointers 0 to 7 | read/write |
| 16 to 63 | unmapped | — |

Top module: `sirq_regbank`

## Requirements
- R1: After reset, every writable register reads zero and both `reevalPulse` and `accessErr` are low.
- R2: A write to select 0 replaces the pending word. `reevalPulse` is high in the cycle after the write.
- R3: A write to select 1 ORs `wrData` into the pending word and raises `reevalPulse` in the next cycle. Reads of select 1 return the pending word.
- R4: A write to select 2 clears exactly the pending bits that are 1 in `wrData` and raises `reevalPulse` in the next cycle. Reads of select 2 return the pending word.
- R5: A write to select 4 (processor state) raises `reevalPulse` only when bit 1 (interrupt enable) goes from 0 to 1. Any other processor-state write leaves the pulse low.
- R6: A write to select 3 (priority level) raises `reevalPulse` only when the new value is unsigned-lower than the stored value.
- R7: Any write to selects 8 to 15 (queue pointers 0 to 7) stores the value and raises `reevalPulse` in the next cycle.
- R8: A write to select 5 (trap base) stores the value with bits 14:0 forced to zero, and reads return it that way.
- R9: Select 6 reads the version word: window count 8 in bits 7:0, maximum trap level 6 in bits 15:8, maximum global level 3 in bits 23:16, zero elsewhere. A write to it changes nothing and sets `accessErr` for one cycle.
- R10: A write to select 7 (hypervisor state) stores `wrData` with bit 11 forced to 1.
- R11: A write to selects 16 to 63 changes no register and sets `accessErr` for one cycle. A read of those selects returns zero.
- R12: `rdData` is combinational. It shows the selected register while `rdEn` is high, and the pre-write value when a write to the same select happens in that cycle. It is zero while `rdEn` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regSel | input | 6 | Register select address |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 64 | Write value |
| rdData | output | 64 | Read value, combinational |
| reevalPulse | output | 1 | One-cycle request to re-evaluate interrupts |
| accessErr | output | 1 | One-cycle flag for a write to an unmapped or read-only select |
| softPend | output | 64 | Soft-interrupt pending word |
| pilLevel | output | 64 | Interrupt priority level |
| pstateWord | output | 64 | Processor-state word |
| trapBase | output | 64 | Trap base address, low 15 bits zero |
| hstateWord | output | 64 | Hypervisor state word |

## Verification
The assertions assume that `wrEn`, `regSel` and `wrData` are stable around the clock edge. They also assume that the cycle before the first checked edge carries no write, so the past-value checks only compare the outcomes of genuine writes. The stimulus changes inputs only at the falling edge and holds `wrEn` low through reset. It then mixes overlapping set and clear masks, priority writes at, above and below the stored level, repeated enable-bit writes, and writes to the version and unmapped selects. Reads are issued in the same cycle as writes to the same select.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int DATA_W   = 64;
  localparam int ADDR_W   = 6;
  localparam int NUM_Q    = 8;
  localparam int Q_IDX_W  = $clog2(NUM_Q);

  localparam logic [ADDR_W-1:0] SEL_SOFT   = 6'd0;
  localparam logic [ADDR_W-1:0] SEL_SET    = 6'd1;
  localparam logic [ADDR_W-1:0] SEL_CLR    = 6'd2;
  localparam logic [ADDR_W-1:0] SEL_PIL    = 6'd3;
  localparam logic [ADDR_W-1:0] SEL_PSTATE = 6'd4;
  localparam logic [ADDR_W-1:0] SEL_TBA    = 6'd5;
  localparam logic [ADDR_W-1:0] SEL_VER    = 6'd6;
  localparam logic [ADDR_W-1:0] SEL_HS     = 6'd7;
  localparam logic [ADDR_W-1:0] SEL_Q0     = 6'd8;

  // write strobes from control to datapath
  typedef struct packed {
    logic               wrSoft;
    logic               wrSet;
    logic               wrClr;
    logic               wrPil;
    logic               wrPstate;
    logic               wrTba;
    logic               wrHs;
    logic               wrQ;
    logic [Q_IDX_W-1:0] qIdx;
  } wrStrobe_t;
endpackage

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
  import sirq_pkg::*;
#(
  parameter int IE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] pilCur,
  input  logic              ieCur,
  output wrStrobe_t         st,
  output logic              reevalPulse,
  output logic              accessErr
);
  localparam logic [ADDR_W-1:0] Q_END = SEL_Q0 + ADDR_W'(NUM_Q);

  logic              isQ;
  logic [ADDR_W-1:0] qOff;
  logic              reevalNext;
  logic              errNext;

  assign isQ  = (regSel >= SEL_Q0) && (regSel < Q_END);
  assign qOff = regSel - SEL_Q0;

  always_comb begin
    st          = '0;
    errNext     = 1'b0;
    st.qIdx     = qOff[Q_IDX_W-1:0];
    if (wrEn) begin
      if (isQ) st.wrQ = 1'b1;
      else begin
        case (regSel)
          SEL_SOFT:   st.wrSoft   = 1'b1;
          SEL_SET:    st.wrSet    = 1'b1;
          SEL_CLR:    st.wrClr    = 1'b1;
          SEL_PIL:    st.wrPil    = 1'b1;
          SEL_PSTATE: st.wrPstate = 1'b1;
          SEL_TBA:    st.wrTba    = 1'b1;
          SEL_HS:     st.wrHs     = 1'b1;
          default:    errNext     = 1'b1;
        endcase
      end
    end
  end

  assign reevalNext = st.wrSoft | st.wrSet | st.wrClr | st.wrQ
                    | (st.wrPil && (wrData < pilCur))
                    | (st.wrPstate && wrData[IE_BIT] && !ieCur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reevalPulse <= 1'b0;
      accessErr   <= 1'b0;
    end else begin
      reevalPulse <= reevalNext;
      accessErr   <= errNext;
    end
  end

  // R11
  err_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accessErr |-> $past(wrEn));
  // R2
  direct_write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && regSel == SEL_SOFT) |=> reevalPulse);
  // R6
  pil_raise_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && regSel == SEL_PIL && wrData >= pilCur) |=> !reevalPulse);
  // R7
  queue_write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && isQ) |=> reevalPulse);
endmodule

// File: rtl/sirq_dpath.sv
module sirq_dpath
  import sirq_pkg::*;
#(
  parameter int TBA_LOW = 15,
  parameter int ID_BIT  = 11,
  parameter int N_WIN   = 8,
  parameter int MAX_TL  = 6,
  parameter int MAX_GL  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wrStrobe_t         st,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] regSel,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] softPend,
  output logic [DATA_W-1:0] pilLevel,
  output logic [DATA_W-1:0] pstateWord,
  output logic [DATA_W-1:0] trapBase,
  output logic [DATA_W-1:0] hstateWord
);
  localparam logic [DATA_W-1:0] TBA_MASK = ~((DATA_W'(1) << TBA_LOW) - DATA_W'(1));
  localparam logic [DATA_W-1:0] ID_MASK  = DATA_W'(1) << ID_BIT;
  localparam logic [DATA_W-1:0] VER_WORD = (DATA_W'(MAX_GL) << 16)
                                         | (DATA_W'(MAX_TL) << 8)
                                         | DATA_W'(N_WIN);

  logic [DATA_W-1:0] qPtr [NUM_Q];
  logic [DATA_W-1:0] rdMux;
  logic [ADDR_W-1:0] rdOff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      softPend   <= '0;
      pilLevel   <= '0;
      pstateWord <= '0;
      trapBase   <= '0;
      hstateWord <= '0;
    end else begin
      if (st.wrSoft)        softPend <= wrData;
      else if (st.wrSet)    softPend <= softPend | wrData;
      else if (st.wrClr)    softPend <= softPend & ~wrData;
      if (st.wrPil)    pilLevel   <= wrData;
      if (st.wrPstate) pstateWord <= wrData;
      if (st.wrTba)    trapBase   <= wrData & TBA_MASK;
      if (st.wrHs)     hstateWord <= wrData | ID_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_Q; i++) qPtr[i] <= '0;
    end else if (st.wrQ) begin
      qPtr[st.qIdx] <= wrData;
    end
  end

  assign rdOff = regSel - SEL_Q0;

  always_comb begin
    rdMux = '0;
    if (regSel >= SEL_Q0 && regSel < SEL_Q0 + ADDR_W'(NUM_Q))
      rdMux = qPtr[rdOff[Q_IDX_W-1:0]];
    else begin
      case (regSel)
        SEL_SOFT, SEL_SET, SEL_CLR: rdMux = softPend;
        SEL_PIL:    rdMux = pilLevel;
        SEL_PSTATE: rdMux = pstateWord;
        SEL_TBA:    rdMux = trapBase & TBA_MASK;
        SEL_VER:    rdMux = VER_WORD;
        SEL_HS:     rdMux = hstateWord;
        default:    rdMux = '0;
      endcase
    end
  end

  assign rdData = rdEn ? rdMux : '0;

  // R3
  set_alias_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st.wrSet |=> ((softPend & $past(wrData)) == $past(wrData)));
  // R4
  clr_alias_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st.wrClr |=> ((softPend & $past(wrData)) == '0));
  // R10
  hs_id_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st.wrHs |=> hstateWord[ID_BIT]);
  // R12
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdEn |-> (rdData == '0));
endmodule

// File: rtl/sirq_regbank.sv
module sirq_regbank
  import sirq_pkg::*;
#(
  parameter int IE_BIT  = 1,
  parameter int TBA_LOW = 15,
  parameter int ID_BIT  = 11,
  parameter int N_WIN   = 8,
  parameter int MAX_TL  = 6,
  parameter int MAX_GL  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              reevalPulse,
  output logic              accessErr,
  output logic [DATA_W-1:0] softPend,
  output logic [DATA_W-1:0] pilLevel,
  output logic [DATA_W-1:0] pstateWord,
  output logic [DATA_W-1:0] trapBase,
  output logic [DATA_W-1:0] hstateWord
);
  wrStrobe_t st;

  sirq_ctrl #(.IE_BIT(IE_BIT)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
    .pilCur(pilLevel), .ieCur(pstateWord[IE_BIT]), .st(st),
    .reevalPulse(reevalPulse), .accessErr(accessErr)
  );

  sirq_dpath #(.TBA_LOW(TBA_LOW), .ID_BIT(ID_BIT), .N_WIN(N_WIN),
               .MAX_TL(MAX_TL), .MAX_GL(MAX_GL)) dpath_i (
    .clk(clk), .rst_n(rst_n), .st(st), .wrData(wrData), .regSel(regSel),
    .rdEn(rdEn), .rdData(rdData), .softPend(softPend), .pilLevel(pilLevel),
    .pstateWord(pstateWord), .trapBase(trapBase), .hstateWord(hstateWord)
  );
endmodule

// File: tb/sirq_regbank_tb.sv
module sirq_regbank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  regSel = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [63:0] wrData = '0;
  logic [63:0] rdData, softPend, pilLevel, pstateWord, trapBase, hstateWord;
  logic        reevalPulse, accessErr;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // behavioural reference state
  logic [63:0] mSoft = '0, mPil = '0, mPs = '0, mTba = '0, mHs = '0;
  logic [63:0] mQ [8];
  logic        mPulse = 1'b0, mErr = 1'b0;
  string       prevTag = "R1";
  localparam logic [63:0] VERSION = 64'h0000_0000_0003_0608;

  sirq_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .reevalPulse(reevalPulse),
    .accessErr(accessErr), .softPend(softPend), .pilLevel(pilLevel),
    .pstateWord(pstateWord), .trapBase(trapBase), .hstateWord(hstateWord)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] modelRead(logic [5:0] s);
    if (s >= 8 && s < 16) return mQ[s - 8];
    case (s)
      0, 1, 2: return mSoft;
      3: return mPil;
      4: return mPs;
      5: return mTba;
      6: return VERSION;
      7: return mHs;
      default: return 64'h0;
    endcase
  endfunction

  // one bus cycle; called at a falling edge
  task automatic step(bit w, bit r, logic [5:0] s, logic [63:0] d, string tag);
    cmp(prevTag, "reevalPulse", 64'(reevalPulse), 64'(mPulse));
    cmp(prevTag, "accessErr", 64'(accessErr), 64'(mErr));
    cmp(prevTag, "softPend", softPend, mSoft);
    cmp(prevTag, "pilLevel", pilLevel, mPil);
    cmp(prevTag, "pstateWord", pstateWord, mPs);
    cmp(prevTag, "trapBase", trapBase, mTba);
    cmp(prevTag, "hstateWord", hstateWord, mHs);
    wrEn = w; rdEn = r; regSel = s; wrData = d;
    #1;
    cmp(tag, "rdData", rdData, r ? modelRead(s) : 64'h0);
    mPulse = 1'b0; mErr = 1'b0;
    if (w) begin
      if (s >= 8 && s < 16) begin mQ[s - 8] = d; mPulse = 1'b1; end
      else case (s)
        0: begin mSoft = d; mPulse = 1'b1; end
        1: begin mSoft = mSoft | d; mPulse = 1'b1; end
        2: begin mSoft = mSoft & ~d; mPulse = 1'b1; end
        3: begin mPulse = (d < mPil); mPil = d; end
        4: begin mPulse = d[1] && !mPs[1]; mPs = d; end
        5: mTba = d & ~64'h7FFF;
        7: mHs = d | 64'h800;
        default: mErr = 1'b1;
      endcase
    end
    prevTag = tag;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mQ[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    for (int s = 0; s < 16; s++) step(0, 1, 6'(s), 64'h0, "R1");
    // R2 direct write
    step(1, 1, 0, 64'hDEAD_BEEF_0000_00F0, "R2");
    step(0, 1, 0, 0, "R2");
    // R3 set alias, overlapping masks
    step(1, 1, 1, 64'h0000_0000_0000_0F0F, "R3");
    step(1, 1, 1, 64'h8000_0000_0000_0000, "R3");
    step(0, 1, 1, 0, "R3");
    // R4 clear alias
    step(1, 1, 2, 64'h0000_0000_0000_00FF, "R4");
    step(1, 1, 2, 64'hFFFF_0000_0000_0000, "R4");
    step(0, 1, 2, 0, "R4");
    // R6 priority level: raise, equal, lower
    step(1, 1, 3, 64'd10, "R6");
    step(1, 1, 3, 64'd10, "R6");
    step(1, 1, 3, 64'd4, "R6");
    step(1, 1, 3, 64'd5, "R6");
    step(0, 1, 3, 0, "R6");
    // R5 enable-bit edge
    step(1, 1, 4, 64'h1, "R5");
    step(1, 1, 4, 64'h2, "R5");
    step(1, 1, 4, 64'h3, "R5");
    step(1, 1, 4, 64'h0, "R5");
    step(1, 1, 4, 64'h6, "R5");
    step(0, 1, 4, 0, "R5");
    // R7 queue pointers
    for (int k = 0; k < 8; k++) step(1, 1, 6'(8 + k), 64'h1000 + 64'(k), "R7");
    for (int k = 0; k < 8; k++) step(0, 1, 6'(8 + k), 0, "R7");
    // R8 trap base
    step(1, 1, 5, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
    step(1, 1, 5, 64'h0000_0000_0001_7FFF, "R8");
    step(0, 1, 5, 0, "R8");
    // R9 version read-only
    step(1, 1, 6, 64'h1234, "R9");
    step(0, 1, 6, 0, "R9");
    // R10 hypervisor state
    step(1, 1, 7, 64'h0, "R10");
    step(1, 1, 7, 64'hF0F0_0000_0000_0001, "R10");
    step(0, 1, 7, 0, "R10");
    // R11 unmapped
    step(1, 1, 16, 64'hAAAA, "R11");
    step(1, 1, 63, 64'h5555, "R11");
    step(0, 1, 40, 0, "R11");
    for (int s = 0; s < 16; s++) step(0, 1, 6'(s), 0, "R11");
    // R12 read gating and pre-write value
    step(1, 0, 0, 64'h77, "R12");
    step(1, 1, 0, 64'h99, "R12");
    step(0, 0, 3, 0, "R12");
    step(0, 1, 0, 0, "R12");
    step(0, 0, 0, 0, "R12");
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule